// File: doc/BRIEF.md
# Event-Action PWM Generator

This block produces six pulse-width-modulated outputs from one shared timebase. A prescaler divides the system clock into counting ticks. A 16-bit counter advances on each tick in one of three shapes: ramp up, ramp down, or triangle. Every channel has its own 16-bit compare value. Four counter events drive each output: the counter at zero, the counter at the period, a compare match while counting up, and a compare match while counting down. For each event a 2-bit action code can leave the output alone, drive it low, drive it high or toggle it.

Software programs the block through a single-cycle write port. Period and compare values go into shadow registers. By default they are copied to the working registers when a new counting cycle starts. Two control bits change this: one loads the values at once, the other also loads them at the period point. Each output passes through a polarity inverter and then a mask override that can force it to a fixed level. Software can also clear the counter.

Top module: `pwm_evgen`

## Requirements
- R1: Write addresses: 0 control, 1 prescaler, 2 period, 3 counter clear, 4 zero/period actions, 5 compare actions, 6 polarity, 7 mask enable, 8 mask level, 9+n compare of channel n. There are six channels, each with its own 16-bit compare value, and one 16-bit period shared by all of them.
- R2: While the working period is 0, the counter does not move and no output changes.
- R3: Control bits [1:0] set the counting shape. 0 counts up 0..P and lasts P+1 ticks. 1 counts down P..0 and lasts P+1 ticks. 2 counts 0 up to P and back down, and lasts 2P ticks; the value 0 belongs to the up phase and the value P to the up phase. The value 3 behaves as 0.
- R4: Action codes are 0 no change, 1 low, 2 high, 3 toggle. At address 4, the zero code of channel n is bits [2n+1:2n] and the period code is bits [17+2n:16+2n]. At address 5, the compare-up code is bits [2n+1:2n] and the compare-down code is bits [17+2n:16+2n].
- R5: When several events fall on one tick, the zero or period action is applied first. The compare action is then applied to that result.
- R6: Without the load bits, a written period or compare value takes effect on the tick that starts the next counting cycle. While the working period is 0, it takes effect at once.
- R7: Control bit 2 (immediate load) makes a written period or compare value take effect on the clock edge that writes it.
- R8: Control bit 3 (center load) also loads the shadow values on the tick where the counter equals the period.
- R9: Prescaler value N (1..0xFFF; 0 acts as 1) gives one counter tick every N clocks.
- R10: A 1 in polarity bit n inverts channel n.
- R11: A 1 in mask-enable bit n forces channel n to mask-level bit n. A mask-enable value of 0 returns the channel to its waveform.
- R12: A write to address 3 sets the counter to 0 and restarts the prescaler. The tick on that edge produces no event.
- R13: After reset all outputs are low, the prescaler is 1 and every other register is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register write address |
| wr_data | input | 32 | Register write data |
| pwm_o | output | 6 | Registered channel outputs |

## Verification
The assertions check on every cycle the properties that are local to one clock edge. A zero period freezes the counter, and a clear zeroes it. The down-counting phase never holds the value 0. Ticks are spaced by the prescaler. Working registers stay unchanged between load points. A channel with no event keeps its level, and an enabled mask forces its level. Only the bench scenarios can show the full waveforms: duty and cycle length in each counting shape, the ordering of events that share a tick, and the cycle in which buffered, immediate and center loads take effect, which is seen through pulse lengths measured around a write.

// File: rtl/pwm_evgen_pkg.sv
package pwm_evgen_pkg;

  typedef enum logic [1:0] {
    MODE_UP  = 2'd0,
    MODE_DN  = 2'd1,
    MODE_UD  = 2'd2,
    MODE_RSV = 2'd3
  } cnt_mode_t;

  localparam int ADR_CTRL  = 0;
  localparam int ADR_PSC   = 1;
  localparam int ADR_PRD   = 2;
  localparam int ADR_CLR   = 3;
  localparam int ADR_ZPACT = 4;
  localparam int ADR_CMACT = 5;
  localparam int ADR_POL   = 6;
  localparam int ADR_MEN   = 7;
  localparam int ADR_MLVL  = 8;
  localparam int ADR_CMP0  = 9;

  // offset of the second code field inside an action word
  localparam int HI_FIELD  = 16;

  function automatic logic act_apply(input logic [1:0] code, input logic v);
    case (code)
      2'd1:    return 1'b0;
      2'd2:    return 1'b1;
      2'd3:    return ~v;
      default: return v;
    endcase
  endfunction

endpackage

// File: rtl/pwm_evgen_regs.sv
module pwm_evgen_regs
  import pwm_evgen_pkg::*;
#(
  parameter int NCH = 6,
  parameter int CW  = 16,
  parameter int PSW = 12,
  parameter int AW  = 4,
  parameter int DW  = 32
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     wr_en,
  input  logic [AW-1:0]            wr_addr,
  input  logic [DW-1:0]            wr_data,
  input  logic                     wrap_i,
  input  logic                     prd_evt_i,
  output cnt_mode_t                mode_o,
  output logic [PSW-1:0]           psc_o,
  output logic [CW-1:0]            prd_o,
  output logic [CW-1:0]            prd_eff_o,
  output logic [NCH-1:0][CW-1:0]   cmp_o,
  output logic [NCH-1:0][1:0]      zact_o,
  output logic [NCH-1:0][1:0]      pact_o,
  output logic [NCH-1:0][1:0]      uact_o,
  output logic [NCH-1:0][1:0]      dact_o,
  output logic [NCH-1:0]           pol_o,
  output logic [NCH-1:0]           men_o,
  output logic [NCH-1:0]           mlvl_o,
  output logic                     clr_o
);

  localparam int TOPBIT = HI_FIELD + 2*NCH;

  logic                   imm_q, ctr_q, ld;
  logic [CW-1:0]          prd_sh, prd_sh_nxt;
  logic [NCH-1:0][CW-1:0] cmp_sh, cmp_sh_nxt;
  logic                   unused_hi;

  assign unused_hi = ^wr_data[DW-1:TOPBIT];

  function automatic logic hit(input int a);
    return wr_en && (wr_addr == AW'(a));
  endfunction

  assign clr_o = hit(ADR_CLR);

  // load point: immediate, stopped counter, cycle start, or center when enabled
  assign ld = imm_q | (prd_o == '0) | wrap_i | (ctr_q & prd_evt_i);

  always_comb begin
    prd_sh_nxt = hit(ADR_PRD) ? wr_data[CW-1:0] : prd_sh;
    for (int n = 0; n < NCH; n++) begin
      cmp_sh_nxt[n] = hit(ADR_CMP0 + n) ? wr_data[CW-1:0] : cmp_sh[n];
    end
  end

  assign prd_eff_o = ld ? prd_sh_nxt : prd_o;

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_o <= MODE_UP;
      imm_q  <= 1'b0;
      ctr_q  <= 1'b0;
      psc_o  <= PSW'(1);
      prd_sh <= '0;
      prd_o  <= '0;
      pol_o  <= '0;
      men_o  <= '0;
      mlvl_o <= '0;
    end else begin
      if (hit(ADR_CTRL)) begin
        mode_o <= cnt_mode_t'(wr_data[1:0]);
        imm_q  <= wr_data[2];
        ctr_q  <= wr_data[3];
      end
      if (hit(ADR_PSC))  psc_o  <= wr_data[PSW-1:0];
      if (hit(ADR_POL))  pol_o  <= wr_data[NCH-1:0];
      if (hit(ADR_MEN))  men_o  <= wr_data[NCH-1:0];
      if (hit(ADR_MLVL)) mlvl_o <= wr_data[NCH-1:0];
      prd_sh <= prd_sh_nxt;
      if (ld) prd_o <= prd_sh_nxt;
    end
  end

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    always_ff @(posedge clk) begin
      if (rst) begin
        cmp_sh[g] <= '0;
        cmp_o[g]  <= '0;
        zact_o[g] <= 2'd0;
        pact_o[g] <= 2'd0;
        uact_o[g] <= 2'd0;
        dact_o[g] <= 2'd0;
      end else begin
        cmp_sh[g] <= cmp_sh_nxt[g];
        if (ld) cmp_o[g] <= cmp_sh_nxt[g];
        if (hit(ADR_ZPACT)) begin
          zact_o[g] <= wr_data[2*g +: 2];
          pact_o[g] <= wr_data[HI_FIELD + 2*g +: 2];
        end
        if (hit(ADR_CMACT)) begin
          uact_o[g] <= wr_data[2*g +: 2];
          dact_o[g] <= wr_data[HI_FIELD + 2*g +: 2];
        end
      end
    end
  end

  // working values move only at a load point (R6)
  p_work_hold_r6: assert property (@(posedge clk) disable iff (rst)
    !ld |=> ($stable(prd_o) && $stable(cmp_o)));

endmodule

// File: rtl/pwm_evgen_base.sv
module pwm_evgen_base
  import pwm_evgen_pkg::*;
#(
  parameter int CW  = 16,
  parameter int PSW = 12
) (
  input  logic            clk,
  input  logic            rst,
  input  cnt_mode_t       mode_i,
  input  logic [PSW-1:0]  psc_i,
  input  logic [CW-1:0]   prd_i,
  input  logic [CW-1:0]   prd_eff_i,
  input  logic            clr_i,
  output logic [CW-1:0]   cnt_o,
  output logic            run_o,
  output logic            wrap_o,
  output logic            zero_evt_o,
  output logic            prd_evt_o,
  output logic            up_ph_o,
  output logic            dn_ph_o
);

  logic [PSW-1:0] pre_q, psc_m1;
  logic           tick, dn_q, dn_n, wrap_c;
  logic [CW-1:0]  cnt_n;

  assign psc_m1 = (psc_i == '0) ? '0 : psc_i - 1'b1;
  assign tick   = (pre_q >= psc_m1);
  assign run_o  = tick && (prd_i != '0) && !clr_i;

  always_ff @(posedge clk) begin
    if (rst || clr_i) pre_q <= '0;
    else              pre_q <= tick ? '0 : pre_q + 1'b1;
  end

  // end of a counting cycle: the next state is the cycle's first value
  always_comb begin
    case (mode_i)
      MODE_DN: wrap_c = (cnt_o == '0);
      MODE_UD: wrap_c = dn_q ? (cnt_o <= CW'(1))
                             : ((cnt_o >= prd_i) && (prd_i == CW'(1)));
      default: wrap_c = (cnt_o >= prd_i);
    endcase
  end

  always_comb begin
    cnt_n = cnt_o;
    dn_n  = 1'b0;
    case (mode_i)
      MODE_DN: begin
        cnt_n = (cnt_o == '0) ? prd_eff_i : cnt_o - 1'b1;
      end
      MODE_UD: begin
        if (dn_q) begin
          cnt_n = (cnt_o <= CW'(1)) ? '0 : cnt_o - 1'b1;
          dn_n  = (cnt_o > CW'(1));
        end else if (cnt_o >= prd_i) begin
          cnt_n = prd_i - 1'b1;
          dn_n  = (prd_i != CW'(1));
        end else begin
          cnt_n = cnt_o + 1'b1;
        end
      end
      default: begin
        cnt_n = (cnt_o >= prd_i) ? '0 : cnt_o + 1'b1;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst || clr_i) begin
      cnt_o <= '0;
      dn_q  <= 1'b0;
    end else if (run_o) begin
      cnt_o <= cnt_n;
      dn_q  <= dn_n;
    end
  end

  assign wrap_o     = run_o && wrap_c;
  assign zero_evt_o = run_o && (cnt_o == '0);
  assign prd_evt_o  = run_o && (cnt_o == prd_i);
  assign up_ph_o    = (mode_i == MODE_DN) ? 1'b0 : !((mode_i == MODE_UD) && dn_q);
  assign dn_ph_o    = (mode_i == MODE_DN) ? 1'b1 : ((mode_i == MODE_UD) && dn_q);

  p_stop_hold_r2: assert property (@(posedge clk) disable iff (rst)
    (prd_i == '0 && !clr_i) |=> $stable(cnt_o));

  p_clear_zero_r12: assert property (@(posedge clk) disable iff (rst)
    clr_i |=> (cnt_o == '0));

  p_down_nonzero_r3: assert property (@(posedge clk) disable iff (rst)
    dn_q |-> (cnt_o != '0));

  p_tick_gap_r9: assert property (@(posedge clk) disable iff (rst)
    (tick && psc_m1 != '0 && !clr_i) |=> (!tick || psc_m1 == '0));

endmodule

// File: rtl/pwm_evgen_chan.sv
module pwm_evgen_chan
  import pwm_evgen_pkg::*;
#(
  parameter int CW = 16
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           run_i,
  input  logic           zero_evt_i,
  input  logic           prd_evt_i,
  input  logic           up_ph_i,
  input  logic           dn_ph_i,
  input  logic [CW-1:0]  cnt_i,
  input  logic [CW-1:0]  cmp_i,
  input  logic [1:0]     zact_i,
  input  logic [1:0]     pact_i,
  input  logic [1:0]     uact_i,
  input  logic [1:0]     dact_i,
  input  logic           pol_i,
  input  logic           men_i,
  input  logic           mlvl_i,
  output logic           pwm_o
);

  logic wave_q, wave_n, cmp_hit;

  assign cmp_hit = run_i && (cnt_i == cmp_i);

  // zero/period action first, compare action applied on top of it
  always_comb begin
    wave_n = wave_q;
    if (zero_evt_i)         wave_n = act_apply(zact_i, wave_n);
    if (prd_evt_i)          wave_n = act_apply(pact_i, wave_n);
    if (cmp_hit && up_ph_i) wave_n = act_apply(uact_i, wave_n);
    if (cmp_hit && dn_ph_i) wave_n = act_apply(dact_i, wave_n);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wave_q <= 1'b0;
      pwm_o  <= 1'b0;
    end else begin
      wave_q <= wave_n;
      pwm_o  <= men_i ? mlvl_i : (wave_n ^ pol_i);
    end
  end

  p_quiet_hold_r4: assert property (@(posedge clk) disable iff (rst)
    !(zero_evt_i || prd_evt_i || cmp_hit) |=> $stable(wave_q));

  p_low_code_r4: assert property (@(posedge clk) disable iff (rst)
    (zero_evt_i && zact_i == 2'd1 && !prd_evt_i && !cmp_hit) |=> !wave_q);

  p_mask_level_r11: assert property (@(posedge clk) disable iff (rst)
    men_i |=> (pwm_o == $past(mlvl_i)));

endmodule

// File: rtl/pwm_evgen.sv
module pwm_evgen
  import pwm_evgen_pkg::*;
#(
  parameter int NCH = 6,
  parameter int CW  = 16,
  parameter int PSW = 12,
  parameter int AW  = 4,
  parameter int DW  = 32
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           wr_en,
  input  logic [AW-1:0]  wr_addr,
  input  logic [DW-1:0]  wr_data,
  output logic [NCH-1:0] pwm_o
);

  cnt_mode_t              mode;
  logic [PSW-1:0]         psc;
  logic [CW-1:0]          prd, prd_eff, cnt;
  logic [NCH-1:0][CW-1:0] cmp;
  logic [NCH-1:0][1:0]    zact, pact, uact, dact;
  logic [NCH-1:0]         pol, men, mlvl;
  logic                   clr, run, wrap, zero_evt, prd_evt, up_ph, dn_ph;

  pwm_evgen_regs #(.NCH(NCH), .CW(CW), .PSW(PSW), .AW(AW), .DW(DW)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .wrap_i(wrap), .prd_evt_i(prd_evt), .mode_o(mode), .psc_o(psc),
    .prd_o(prd), .prd_eff_o(prd_eff), .cmp_o(cmp), .zact_o(zact),
    .pact_o(pact), .uact_o(uact), .dact_o(dact), .pol_o(pol),
    .men_o(men), .mlvl_o(mlvl), .clr_o(clr)
  );

  pwm_evgen_base #(.CW(CW), .PSW(PSW)) u_base (
    .clk(clk), .rst(rst), .mode_i(mode), .psc_i(psc), .prd_i(prd),
    .prd_eff_i(prd_eff), .clr_i(clr), .cnt_o(cnt), .run_o(run),
    .wrap_o(wrap), .zero_evt_o(zero_evt), .prd_evt_o(prd_evt),
    .up_ph_o(up_ph), .dn_ph_o(dn_ph)
  );

  for (genvar g = 0; g < NCH; g++) begin : g_chan
    pwm_evgen_chan #(.CW(CW)) u_chan (
      .clk(clk), .rst(rst), .run_i(run), .zero_evt_i(zero_evt),
      .prd_evt_i(prd_evt), .up_ph_i(up_ph), .dn_ph_i(dn_ph),
      .cnt_i(cnt), .cmp_i(cmp[g]), .zact_i(zact[g]), .pact_i(pact[g]),
      .uact_i(uact[g]), .dact_i(dact[g]), .pol_i(pol[g]), .men_i(men[g]),
      .mlvl_i(mlvl[g]), .pwm_o(pwm_o[g])
    );
  end

endmodule

// File: tb/pwm_evgen_bench.sv
`timescale 1ns/1ps
module pwm_evgen_bench;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [3:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [5:0]  pwm_o;
  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  pwm_evgen u_pwm_evgen (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .pwm_o(pwm_o)
  );

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not finish (act timeout, exp completion)");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: act %0d exp %0d", req, act, exp);
    end
  endtask

  function automatic logic [31:0] fld(input int ch, input int code, input bit hi);
    return 32'(code) << (2*ch + (hi ? 16 : 0));
  endfunction

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 4'(a); wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic settle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic count_high(input int ch, input int n, output int h);
    h = 0;
    repeat (n) begin
      @(negedge clk);
      if (pwm_o[ch]) h++;
    end
  endtask

  // leaves the caller at the negedge where channel ch was first seen high
  task automatic wait_rise(input int ch);
    logic prev = pwm_o[ch];
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      if (pwm_o[ch] && !prev) return;
      prev = pwm_o[ch];
    end
  endtask

  task automatic wait_fall(input int ch);
    logic prev = pwm_o[ch];
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      if (!pwm_o[ch] && prev) return;
      prev = pwm_o[ch];
    end
  endtask

  task automatic rise_gap(input int ch, output int g);
    wait_rise(ch);
    g = 0;
    begin
      logic prev = pwm_o[ch];
      for (int i = 0; i < 3000; i++) begin
        @(negedge clk);
        g++;
        if (pwm_o[ch] && !prev) return;
        prev = pwm_o[ch];
      end
    end
  endtask

  // called at the rising negedge; optionally issues a write there
  task automatic pulse_with_write(input int ch, input bit do_wr, input int a,
                                  input logic [31:0] d, output int len);
    if (do_wr) begin wr_en = 1'b1; wr_addr = 4'(a); wr_data = d; end
    len = 1;
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      wr_en = 1'b0;
      if (!pwm_o[ch]) return;
      len++;
    end
  endtask

  task automatic halt();
    wr(0, 32'h4);
    wr(2, 32'h0);
    wr(3, 32'h0);
    wr(4, 32'h0);
    wr(5, 32'h0);
  endtask

  task automatic t_reset();
    chk("R13 outputs low after reset", int'(pwm_o), 0);
  endtask

  task automatic t_down();
    int h, g;
    halt();
    wr(0, 32'h1);
    wr(9 + 2, 32'd3);
    wr(4, fld(2, 2, 1));
    wr(5, fld(2, 1, 1));
    wr(2, 32'd9);
    settle(40);
    count_high(2, 10, h);
    chk("R3 down-count duty ch2", h, 6);
    rise_gap(2, g);
    chk("R3 down-count cycle length", g, 10);
  endtask

  task automatic t_updown();
    int h, g;
    halt();
    wr(0, 32'h2);
    wr(9, 32'd3);
    wr(5, fld(0, 2, 0) | fld(0, 1, 1));
    wr(2, 32'd8);
    settle(40);
    count_high(0, 16, h);
    chk("R3 up-down duty ch0", h, 10);
    rise_gap(0, g);
    chk("R3 up-down cycle length 2P", g, 16);
  endtask

  task automatic up_cfg();
    halt();
    wr(0, 32'h0);
    wr(9 + 5, 32'd2);
    wr(9 + 4, 32'd5);
    wr(4, fld(5, 2, 0) | fld(4, 2, 0));
    wr(5, fld(5, 1, 0) | fld(4, 1, 0));
    wr(2, 32'd7);
    settle(40);
  endtask

  task automatic t_up();
    int h, g;
    up_cfg();
    count_high(5, 8, h);
    chk("R4 up-count zero-high cmp-low ch5", h, 2);
    count_high(4, 8, h);
    chk("R1 independent compare ch4", h, 5);
    rise_gap(5, g);
    chk("R3 up-count cycle length P+1", g, 8);
  endtask

  task automatic t_toggle_psc();
    int h, g;
    halt();
    wr(0, 32'h0);
    wr(4, fld(1, 3, 0));
    wr(2, 32'd3);
    settle(40);
    count_high(1, 8, h);
    chk("R4 toggle at zero duty", h, 4);
    rise_gap(1, g);
    chk("R4 toggle cycle", g, 8);
    wr(1, 32'd3);
    settle(60);
    rise_gap(1, g);
    chk("R9 prescaler 3 stretches cycle", g, 24);
    wr(1, 32'd1);
  endtask

  task automatic t_priority();
    int h;
    halt();
    wr(0, 32'h0);
    wr(9 + 3, 32'd0);
    wr(9 + 1, 32'd0);
    wr(4, fld(3, 2, 0) | fld(1, 1, 0));
    wr(5, fld(3, 1, 0) | fld(1, 3, 0));
    wr(2, 32'd4);
    settle(40);
    count_high(3, 10, h);
    chk("R5 compare low beats zero high", h, 0);
    count_high(1, 10, h);
    chk("R5 toggle applied after zero low", h, 10);
  endtask

  task automatic t_pol_mask();
    int h;
    up_cfg();
    wr(6, 32'h20);
    settle(4);
    count_high(5, 8, h);
    chk("R10 polarity inverts ch5", h, 6);
    wr(8, 32'h20);
    wr(7, 32'h30);
    settle(4);
    count_high(5, 8, h);
    chk("R11 mask forces ch5 high", h, 8);
    count_high(4, 8, h);
    chk("R11 mask forces ch4 low", h, 0);
    wr(7, 32'h0);
    wr(6, 32'h0);
    settle(4);
    count_high(5, 8, h);
    chk("R11 mask off restores ch5", h, 2);
  endtask

  task automatic t_load();
    int len;
    up_cfg();
    wait_rise(5);
    pulse_with_write(5, 1'b1, 9 + 5, 32'd5, len);
    chk("R6 buffered compare keeps current pulse", len, 2);
    wait_rise(5);
    pulse_with_write(5, 1'b0, 0, 32'd0, len);
    chk("R6 buffered compare used next cycle", len, 5);
    wr(9 + 5, 32'd2);
    wr(0, 32'h4);
    settle(30);
    wait_rise(5);
    pulse_with_write(5, 1'b1, 9 + 5, 32'd5, len);
    chk("R7 immediate load changes current pulse", len, 5);
  endtask

  task automatic t_center();
    int len;
    halt();
    wr(0, 32'hA);
    wr(9, 32'd3);
    wr(5, fld(0, 2, 0) | fld(0, 1, 1));
    wr(2, 32'd8);
    settle(40);
    wait_rise(0);
    pulse_with_write(0, 1'b1, 9, 32'd6, len);
    chk("R8 center load applies at period point", len, 7);
  endtask

  task automatic t_clear();
    int low;
    up_cfg();
    wait_fall(5);
    wr_en = 1'b1; wr_addr = 4'd3; wr_data = '0;
    low = 1;
    for (int i = 0; i < 100; i++) begin
      @(negedge clk);
      wr_en = 1'b0;
      if (pwm_o[5]) break;
      low++;
    end
    chk("R12 clear restarts cycle early", low, 2);
  endtask

  task automatic t_stop();
    int g, chg;
    logic v;
    halt();
    wr(0, 32'h0);
    wr(4, fld(1, 3, 0));
    wr(2, 32'd3);
    settle(20);
    rise_gap(1, g);
    chk("R2 running before stop", g, 8);
    wr(0, 32'h4);
    wr(2, 32'd0);
    settle(3);
    v = pwm_o[1];
    chg = 0;
    repeat (30) begin
      @(negedge clk);
      if (pwm_o[1] != v) chg++;
    end
    chk("R2 zero period freezes output", chg, 0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_down();
    t_updown();
    t_up();
    t_toggle_psc();
    t_priority();
    t_pol_mask();
    t_load();
    t_center();
    t_clear();
    t_stop();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule